// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC. When a frame's destination address has been collected, the parser pulses a strobe. On that strobe the block compares the address with the station's own address. It classifies the frame as unicast, multicast or broadcast. It then applies one of four acceptance policies and says whether the frame should be kept or dropped.

Alongside the decision it produces classification flags for the receive status word. It also returns a 32-bit status fragment with those flags at the positions the status writer expects. The multicast hash lookup is done elsewhere, and only its one-bit hit result enters here.

When receive DMA is enabled, a hash hit seen on a strobe is caught in a sticky bit. That bit stays set until an explicit clear pulse.

Top module: `rx_dest_filter`

## Requirements
- R1: `out_valid` pulses high for exactly one cycle, one clock after each `addr_vld` cycle. All result outputs are captured on that strobe and hold their values until the next strobe, whatever the inputs do meanwhile.
- R2: `bcast` is 1 exactly when all 48 destination bits are ones.
- R3: `mcast` is 1 when destination bit 40 is one and the frame is not broadcast. Bit 40 is the least significant bit of the first byte on the wire, which is `dest_addr[47:40]`.
- R4: `phys_match` is 1 exactly when `dest_addr` equals `station_addr` in all 48 bits. This holds even when the station address has its group bit set.
- R5: `mcast_hit` is 1 exactly when the frame is multicast and `hash_hit` was 1 on the strobe. Broadcast and unicast frames never raise it.
- R6: With `filt_mode` = 2'b00, `accept` equals `phys_match`.
- R7: With `filt_mode` = 2'b01, `accept` is 1 for a physical match, a broadcast, or a multicast with a hash hit. Otherwise it is 0.
- R8: With `filt_mode` = 2'b10, `accept` is 1 for a physical match, a broadcast, or any multicast. Otherwise it is 0.
- R9: With `filt_mode` = 2'b11, `accept` is 1 for every frame.
- R10: `stat_word` carries `phys_match` at bit 26, `mcast_hit` at bit 25, `bcast` at bit 20 and `mcast` at bit 19. Every other bit is 0.
- R11: `hash_sticky` goes to 1 after a strobe on which both `rx_dma_en` and `hash_hit` are 1. It then stays 1. A strobe with `rx_dma_en` at 0 never sets it.
- R12: A `hash_sticky_clr` pulse clears `hash_sticky` on the next clock. When a set and a clear happen in the same cycle, the set wins.
- R13: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | Destination address strobe |
| dest_addr | input | 48 | Destination address; first wire byte in [47:40] |
| station_addr | input | 48 | Station's own address |
| filt_mode | input | 2 | Acceptance policy select |
| hash_hit | input | 1 | Result of the external multicast hash lookup |
| rx_dma_en | input | 1 | Receive DMA enabled; gates the sticky capture |
| hash_sticky_clr | input | 1 | Clear pulse for the sticky hash bit |
| out_valid | output | 1 | Results updated this cycle |
| accept | output | 1 | Keep the frame |
| phys_match | output | 1 | Destination equals station address |
| mcast_hit | output | 1 | Multicast frame that hit the hash filter |
| bcast | output | 1 | Broadcast frame |
| mcast | output | 1 | Multicast, non-broadcast frame |
| stat_word | output | 32 | Status fragment with flags at fixed bit positions |
| hash_sticky | output | 1 | Sticky capture of the hash hit |

## Verification
Six address patterns are driven under each of the four modes:
- own address
- all ones
- a group address with the hash hitting
- a group address with the hash missing
- a unicast address one bit away from the station address, with the hash line high
- a station address that itself has the group bit set

Running the same patterns in every mode separates each policy from its neighbours. The near-miss unicast exposes a partial comparator, and the all-ones pattern shows broadcast taking priority over multicast. Idle cycles with changing inputs show that the results hold. A short sequence with the DMA enable toggled, plus coincident set and clear, pins down the sticky bit.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int MAC_W      = 48;
    localparam int STAT_W     = 32;
    localparam int ST_PHYS_B  = 26;
    localparam int ST_HASH_B  = 25;
    localparam int ST_BCAST_B = 20;
    localparam int ST_MCAST_B = 19;

    typedef enum logic [1:0] {
        FM_OWN     = 2'b00,
        FM_HASHED  = 2'b01,
        FM_ALLGRP  = 2'b10,
        FM_PROMISC = 2'b11
    } filt_mode_e;

    typedef struct packed {
        logic phys;
        logic hash;
        logic bcast;
        logic mcast;
    } addr_class_t;

    function automatic logic [STAT_W-1:0] pack_status(addr_class_t c);
        logic [STAT_W-1:0] w;
        w             = '0;
        w[ST_PHYS_B]  = c.phys;
        w[ST_HASH_B]  = c.hash;
        w[ST_BCAST_B] = c.bcast;
        w[ST_MCAST_B] = c.mcast;
        return w;
    endfunction

endpackage

// File: rtl/rxaf_classify.sv
module rxaf_classify
    import rxaf_pkg::*;
#(
    parameter int ADDR_W = MAC_W
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] own,
    input  logic              hash_in,
    output addr_class_t       cls
);
    localparam int NBYTES = ADDR_W / 8;
    localparam int GRP_B  = ADDR_W - 8;

    logic [NBYTES-1:0] byte_eq;
    logic [NBYTES-1:0] byte_ones;

    // Per-byte compare lanes
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign byte_eq[b]   = (dest[b*8 +: 8] == own[b*8 +: 8]);
        assign byte_ones[b] = &dest[b*8 +: 8];
    end

    logic is_bc;
    logic is_mc;

    assign is_bc = &byte_ones;
    assign is_mc = dest[GRP_B] & ~is_bc;

    always_comb begin
        cls.phys  = &byte_eq;
        cls.bcast = is_bc;
        cls.mcast = is_mc;
        cls.hash  = is_mc & hash_in;
    end
endmodule

// File: rtl/rxaf_policy.sv
module rxaf_policy
    import rxaf_pkg::*;
(
    input  filt_mode_e  mode,
    input  addr_class_t cls,
    output logic        keep
);
    always_comb begin
        unique case (mode)
            FM_OWN:     keep = cls.phys;
            FM_HASHED:  keep = cls.phys | cls.bcast | cls.hash;
            FM_ALLGRP:  keep = cls.phys | cls.bcast | cls.mcast;
            FM_PROMISC: keep = 1'b1;
            default:    keep = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxaf_result_reg.sv
module rxaf_result_reg
    import rxaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  addr_class_t       cls_in,
    input  logic              keep_in,
    input  logic              raw_hash,
    input  logic              dma_en,
    input  logic              sticky_clr,
    output logic              vld_q,
    output logic              keep_q,
    output addr_class_t       cls_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              sticky_q
);
    logic sticky_set;

    assign sticky_set = strobe & dma_en & raw_hash;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= 1'b0;
            keep_q   <= 1'b0;
            cls_q    <= '0;
            stat_q   <= '0;
            sticky_q <= 1'b0;
        end else begin
            vld_q <= strobe;
            if (strobe) begin
                keep_q <= keep_in;
                cls_q  <= cls_in;
                stat_q <= pack_status(cls_in);
            end
            // set has priority over a coincident clear
            sticky_q <= (sticky_q & ~sticky_clr) | sticky_set;
        end
    end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxaf_pkg::*;
#(
    parameter int ADDR_W = MAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [1:0]        filt_mode,
    input  logic              hash_hit,
    input  logic              rx_dma_en,
    input  logic              hash_sticky_clr,
    output logic              out_valid,
    output logic              accept,
    output logic              phys_match,
    output logic              mcast_hit,
    output logic              bcast,
    output logic              mcast,
    output logic [STAT_W-1:0] stat_word,
    output logic              hash_sticky
);
    addr_class_t cls_now;
    addr_class_t cls_reg;
    logic        keep_now;

    rxaf_classify #(.ADDR_W(ADDR_W)) u_cls (
        .dest    (dest_addr),
        .own     (station_addr),
        .hash_in (hash_hit),
        .cls     (cls_now)
    );

    rxaf_policy u_pol (
        .mode (filt_mode_e'(filt_mode)),
        .cls  (cls_now),
        .keep (keep_now)
    );

    rxaf_result_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .strobe     (addr_vld),
        .cls_in     (cls_now),
        .keep_in    (keep_now),
        .raw_hash   (hash_hit),
        .dma_en     (rx_dma_en),
        .sticky_clr (hash_sticky_clr),
        .vld_q      (out_valid),
        .keep_q     (accept),
        .cls_q      (cls_reg),
        .stat_q     (stat_word),
        .sticky_q   (hash_sticky)
    );

    assign phys_match = cls_reg.phys;
    assign mcast_hit  = cls_reg.hash;
    assign bcast      = cls_reg.bcast;
    assign mcast      = cls_reg.mcast;
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk (
    input logic        clk,
    input logic        rst,
    input logic        addr_vld,
    input logic [1:0]  filt_mode,
    input logic        hash_hit,
    input logic        rx_dma_en,
    input logic        hash_sticky_clr,
    input logic        out_valid,
    input logic        accept,
    input logic        phys_match,
    input logic        mcast_hit,
    input logic        bcast,
    input logic        mcast,
    input logic [31:0] stat_word,
    input logic        hash_sticky
);
    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        addr_vld |=> out_valid);

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_vld |=> (!out_valid && $stable(accept) && $stable(stat_word)));

    // R3
    bc_mc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bcast && mcast));

    // R5
    hit_needs_mc_chk: assert property (@(posedge clk) disable iff (rst)
        mcast_hit |-> mcast);

    // R6
    own_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && filt_mode == 2'b00) |=> (accept == phys_match));

    // R9
    promisc_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && filt_mode == 2'b11) |=> accept);

    // R11
    sticky_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hash_sticky) |-> $past(addr_vld && rx_dma_en && hash_hit));

    // R12
    sticky_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hash_sticky) |-> $past(hash_sticky_clr));
endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .addr_vld        (addr_vld),
    .filt_mode       (filt_mode),
    .hash_hit        (hash_hit),
    .rx_dma_en       (rx_dma_en),
    .hash_sticky_clr (hash_sticky_clr),
    .out_valid       (out_valid),
    .accept          (accept),
    .phys_match      (phys_match),
    .mcast_hit       (mcast_hit),
    .bcast           (bcast),
    .mcast           (mcast),
    .stat_word       (stat_word),
    .hash_sticky     (hash_sticky)
);

// File: tb/rx_dest_filter_tb.sv
`timescale 1ns/1ps
module rx_dest_filter_tb;

    typedef struct packed {
        logic [1:0]  mode;
        logic        acc;
        logic        ph;
        logic        mh;
        logic        bc;
        logic        mc;
        logic [31:0] st;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_vld = 1'b0;
    logic [47:0] dest_addr = '0;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic [1:0]  filt_mode = 2'b00;
    logic        hash_hit = 1'b0;
    logic        rx_dma_en = 1'b0;
    logic        hash_sticky_clr = 1'b0;
    logic        out_valid, accept, phys_match, mcast_hit, bcast, mcast, hash_sticky;
    logic [31:0] stat_word;

    int   errors = 0;
    int   checks = 0;
    bit   running = 1'b0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp = '0;

    always #2.5 clk = ~clk;

    rx_dest_filter u_dut (
        .clk(clk), .rst(rst), .addr_vld(addr_vld), .dest_addr(dest_addr),
        .station_addr(station_addr), .filt_mode(filt_mode), .hash_hit(hash_hit),
        .rx_dma_en(rx_dma_en), .hash_sticky_clr(hash_sticky_clr),
        .out_valid(out_valid), .accept(accept), .phys_match(phys_match),
        .mcast_hit(mcast_hit), .bcast(bcast), .mcast(mcast),
        .stat_word(stat_word), .hash_sticky(hash_sticky)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic exp_t model(input logic [47:0] d, input logic [47:0] own,
                                   input logic [1:0] m, input logic h);
        exp_t e;
        e      = '0;
        e.mode = m;
        e.bc   = (d == 48'hFFFF_FFFF_FFFF);               // R2
        e.mc   = d[40] && !e.bc;                           // R3
        e.ph   = (d == own);                               // R4
        e.mh   = e.mc && h;                                // R5
        case (m)
            2'b00: e.acc = e.ph;                           // R6
            2'b01: e.acc = e.ph || e.bc || e.mh;           // R7
            2'b10: e.acc = e.ph || e.bc || e.mc;           // R8
            default: e.acc = 1'b1;                         // R9
        endcase
        e.st[26] = e.ph;                                   // R10
        e.st[25] = e.mh;
        e.st[20] = e.bc;
        e.st[19] = e.mc;
        return e;
    endfunction

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00: return "R6";
            2'b01: return "R7";
            2'b10: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input exp_t e, input string tag);
        chk(accept == e.acc, {mode_req(e.mode), tag}, 48'(accept), 48'(e.acc));
        chk(phys_match == e.ph, {"R4", tag}, 48'(phys_match), 48'(e.ph));
        chk(bcast == e.bc, {"R2", tag}, 48'(bcast), 48'(e.bc));
        chk(mcast == e.mc, {"R3", tag}, 48'(mcast), 48'(e.mc));
        chk(mcast_hit == e.mh, {"R5", tag}, 48'(mcast_hit), 48'(e.mh));
        chk(stat_word == e.st, {"R10", tag}, 48'(stat_word), 48'(e.st));
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (running && !rst) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected out_valid", 48'd1, 48'd0);
                end else begin
                    last_exp = sb_q.pop_front();
                    compare(last_exp, "");
                end
            end else begin
                compare(last_exp, " R1 hold");
            end
        end
    end

    task automatic drive(input logic [47:0] d, input logic [1:0] m, input logic h,
                         input logic dma, input logic clr);
        dest_addr       = d;
        filt_mode       = m;
        hash_hit        = h;
        rx_dma_en       = dma;
        hash_sticky_clr = clr;
        addr_vld        = 1'b1;
        sb_q.push_back(model(d, station_addr, m, h));
        @(negedge clk);
        addr_vld        = 1'b0;
        hash_sticky_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            dest_addr = {dest_addr[46:0], ~dest_addr[47]} ^ 48'h1;
            filt_mode = filt_mode + 2'd1;
            hash_hit  = ~hash_hit;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (sb_q.size() != 0) chk(1'b0, "R1 results missing", 48'(sb_q.size()), 48'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 48'd0, 48'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] pats [6];
        logic        hits [6];
        pats[0] = 48'h02_11_22_33_44_55; hits[0] = 1'b0;   // own
        pats[1] = 48'hFF_FF_FF_FF_FF_FF; hits[1] = 1'b1;   // broadcast
        pats[2] = 48'h01_00_5E_00_00_FB; hits[2] = 1'b1;   // group, hash hit
        pats[3] = 48'h01_00_5E_00_00_FB; hits[3] = 1'b0;   // group, hash miss
        pats[4] = 48'h02_11_22_33_44_54; hits[4] = 1'b1;   // near-miss unicast

        repeat (3) @(negedge clk);
        // R13: reset values
        chk({out_valid, accept, phys_match, mcast_hit, bcast, mcast, hash_sticky} == 7'b0,
            "R13 flags", 48'({out_valid, accept, phys_match, mcast_hit, bcast, mcast, hash_sticky}), 48'd0);
        chk(stat_word == 32'd0, "R13 stat", 48'(stat_word), 48'd0);
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);

        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 5; p++) begin
                drive(pats[p], 2'(m), hits[p], 1'b0, 1'b0);
            end
            idle(2);
            // back-to-back variant
            drive(pats[2], 2'(m), 1'b0, 1'b0, 1'b0);
            drive(pats[1], 2'(m), 1'b0, 1'b0, 1'b0);
            idle(1);
        end

        // R4: station address with the group bit set
        station_addr = 48'h01_AA_BB_CC_DD_EE;
        for (int m = 0; m < 4; m++) drive(48'h01_AA_BB_CC_DD_EE, 2'(m), 1'b0, 1'b0, 1'b0);
        drive(48'h01_AA_BB_CC_DD_EF, 2'b00, 1'b1, 1'b0, 1'b0);
        idle(2);

        // R11: no capture while DMA disabled (hash hits above)
        chk(hash_sticky == 1'b0, "R11 dma off", 48'(hash_sticky), 48'd0);
        drive(pats[4], 2'b00, 1'b1, 1'b1, 1'b0);
        chk(hash_sticky == 1'b1, "R11 set", 48'(hash_sticky), 48'd1);
        drive(pats[0], 2'b00, 1'b0, 1'b1, 1'b0);
        idle(2);
        chk(hash_sticky == 1'b1, "R11 hold", 48'(hash_sticky), 48'd1);
        // R12: clear pulse alone
        hash_sticky_clr = 1'b1;
        @(negedge clk);
        hash_sticky_clr = 1'b0;
        chk(hash_sticky == 1'b0, "R12 clear", 48'(hash_sticky), 48'd0);
        // R12: set and clear together, set wins
        drive(pats[2], 2'b01, 1'b1, 1'b1, 1'b1);
        chk(hash_sticky == 1'b1, "R12 set wins", 48'(hash_sticky), 48'd1);
        idle(3);

        done = 1'b1;
        finish_run();
    end

endmodule